// File: doc/BRIEF.md
# Collision Indicator Controller with Jabber and Heartbeat

This block drives the differential collision-indicator pair of a coaxial transceiver. A free-running divider turns the sampling clock into a 10 MHz square wave. The wave is gated onto the pair whenever one of three sources asks for it. The sources are a collision flag from the analog comparator, a jabber latch that trips when a transmission runs too long, and a heartbeat burst sent shortly after each transmission ends. When no source is active, both legs sit low, which gives zero differential.

The jabber latch also drives a transmit-inhibit output that turns off the line driver. The latch releases only after the transmit-valid input has been quiet for a long, unbroken period. A heartbeat burst begins a fixed delay after each end-of-transmission pulse and lasts a fixed length. A strap input suppresses the heartbeat. All timer lengths are parameters counted in sampling-clock cycles, so simulation can use short values.

Top module: `collision_ind_ctrl`

## Requirements
- R1: While reset is asserted and right after it, both indicator legs and the transmit-inhibit output are 0, and no jabber or heartbeat state is kept.
- R2: When the indicator is off, both legs are 0. When it is on, exactly one leg is 1 in every cycle.
- R3: While the collision flag is 1, the indicator is on. The positive leg is high for CLK_DIV/2 of every CLK_DIV consecutive cycles, from a divider that never stops.
- R4: After JAB_LIMIT consecutive cycles with transmit-valid at 1, the jabber latch sets. From that point transmit-inhibit is 1 and the indicator is on. After JAB_LIMIT-1 such cycles, neither has happened yet.
- R5: A cycle with transmit-valid at 0 before the limit is reached clears the run count. Two runs of JAB_LIMIT-1 valid cycles separated by one quiet cycle do not set the latch.
- R6: The latch clears after UNJAB_TICKS consecutive cycles with transmit-valid at 0. Transmit-inhibit and the indicator then drop. They are still set after UNJAB_TICKS-1 such cycles.
- R7: Any transmit-valid cycle while the latch is set restarts the quiet count from zero.
- R8: An end-of-transmission pulse sampled at clock edge E starts a heartbeat burst. The indicator is on from edge E+HB_DELAY through the cycle before edge E+HB_DELAY+HB_LEN.
- R9: A new end-of-transmission pulse while a heartbeat is pending or running restarts the delay from that pulse.
- R10: While the heartbeat-enable strap is 0, end-of-transmission pulses produce no burst, and any pending burst is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (CLK_DIV times 10 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| coll_det_i | input | 1 | Collision flag from the comparator |
| tx_valid_i | input | 1 | Transmit data valid |
| tx_end_i | input | 1 | Single-cycle end-of-transmission pulse |
| hb_en_i | input | 1 | Heartbeat enable strap, 1 = enabled |
| ind_p_o | output | 1 | Indicator positive leg |
| ind_n_o | output | 1 | Indicator negative leg |
| tx_inhibit_o | output | 1 | Transmit driver disable while jabbering |

## Verification
The hardest state to reach is an unjab period that gets interrupted. To get there, the latch must first be tripped with an exact-length transmit run. Then the input has to stay quiet part way through the release period, and a single valid cycle is injected. After that, release must come exactly UNJAB_TICKS quiet cycles after the injected cycle, and not after the first quiet stretch began. The bench uses short timer parameters. It drives exact cycle counts for each of these stretches and checks the inhibit output one cycle before and one cycle at each boundary. The heartbeat retrigger is reached the same way: a second end pulse lands inside the pending delay.

// File: rtl/ci_pkg.sv
package ci_pkg;
  typedef enum logic [1:0] {
    HB_IDLE  = 2'd0,
    HB_WAIT  = 2'd1,
    HB_BURST = 2'd2
  } hb_state_t;
endpackage

// File: rtl/ci_tone_div.sv
module ci_tone_div #(
  parameter int CLK_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tone_o
);
  localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int HALF = CLK_DIV / 2;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == CW'(CLK_DIV - 1)) cnt_d = '0;
    else                           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tone_o = (cnt_q < CW'(HALF));
endmodule

// File: rtl/ci_jabber.sv
module ci_jabber #(
  parameter int JAB_LIMIT   = 2000000,
  parameter int UNJAB_TICKS = 50000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_valid_i,
  output logic latched_o
);
  localparam int RW = $clog2(JAB_LIMIT + 1);
  localparam int QW = $clog2(UNJAB_TICKS + 1);

  logic          lat_q, lat_d;
  logic [RW-1:0] run_q, run_d;
  logic [QW-1:0] quiet_q, quiet_d;
  logic          run_en, quiet_en;

  always_comb begin
    lat_d    = lat_q;
    run_d    = run_q;
    quiet_d  = quiet_q;
    run_en   = 1'b0;
    quiet_en = 1'b0;
    if (!lat_q) begin
      run_en = 1'b1;
      if (!tx_valid_i) begin
        run_d = '0;
      end else if (run_q == RW'(JAB_LIMIT - 1)) begin
        lat_d    = 1'b1;
        run_d    = '0;
        quiet_en = 1'b1;
        quiet_d  = '0;
      end else begin
        run_d = run_q + 1'b1;
      end
    end else begin
      quiet_en = 1'b1;
      if (tx_valid_i) begin
        quiet_d = '0;
      end else if (quiet_q == QW'(UNJAB_TICKS - 1)) begin
        lat_d   = 1'b0;
        quiet_d = '0;
        run_en  = 1'b1;
        run_d   = '0;
      end else begin
        quiet_d = quiet_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q   <= 1'b0;
      run_q   <= '0;
      quiet_q <= '0;
    end else begin
      lat_q <= lat_d;
      if (run_en)   run_q   <= run_d;
      if (quiet_en) quiet_q <= quiet_d;
    end
  end

  assign latched_o = lat_q;
endmodule

// File: rtl/ci_heartbeat.sv
module ci_heartbeat
  import ci_pkg::*;
#(
  parameter int HB_DELAY = 110,
  parameter int HB_LEN   = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hb_en_i,
  input  logic tx_end_i,
  output logic burst_o
);
  localparam int MAXT = (HB_DELAY > HB_LEN) ? HB_DELAY : HB_LEN;
  localparam int TW   = $clog2(MAXT + 1);

  hb_state_t     st_q, st_d;
  logic [TW-1:0] tm_q, tm_d;

  always_comb begin
    st_d = st_q;
    tm_d = tm_q;
    if (!hb_en_i) begin
      st_d = HB_IDLE;
      tm_d = '0;
    end else if (tx_end_i) begin
      st_d = HB_WAIT;
      tm_d = '0;
    end else begin
      case (st_q)
        HB_WAIT: begin
          if (tm_q == TW'(HB_DELAY - 1)) begin
            st_d = HB_BURST;
            tm_d = '0;
          end else begin
            tm_d = tm_q + 1'b1;
          end
        end
        HB_BURST: begin
          if (tm_q == TW'(HB_LEN - 1)) begin
            st_d = HB_IDLE;
            tm_d = '0;
          end else begin
            tm_d = tm_q + 1'b1;
          end
        end
        default: begin
          st_d = HB_IDLE;
          tm_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= HB_IDLE;
      tm_q <= '0;
    end else begin
      st_q <= st_d;
      tm_q <= tm_d;
    end
  end

  assign burst_o = (st_q == HB_BURST);
endmodule

// File: rtl/collision_ind_ctrl.sv
module collision_ind_ctrl #(
  parameter int CLK_DIV     = 10,
  parameter int JAB_LIMIT   = 2000000,
  parameter int UNJAB_TICKS = 50000000,
  parameter int HB_DELAY    = 110,
  parameter int HB_LEN      = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic coll_det_i,
  input  logic tx_valid_i,
  input  logic tx_end_i,
  input  logic hb_en_i,
  output logic ind_p_o,
  output logic ind_n_o,
  output logic tx_inhibit_o
);
  logic tone, jab, burst, ind_on;

  ci_tone_div #(.CLK_DIV(CLK_DIV)) u_tone (
    .clk(clk), .rst_n(rst_n), .tone_o(tone)
  );

  ci_jabber #(.JAB_LIMIT(JAB_LIMIT), .UNJAB_TICKS(UNJAB_TICKS)) u_jab (
    .clk(clk), .rst_n(rst_n), .tx_valid_i(tx_valid_i), .latched_o(jab)
  );

  ci_heartbeat #(.HB_DELAY(HB_DELAY), .HB_LEN(HB_LEN)) u_hb (
    .clk(clk), .rst_n(rst_n), .hb_en_i(hb_en_i), .tx_end_i(tx_end_i),
    .burst_o(burst)
  );

  assign ind_on       = coll_det_i | jab | burst;
  assign ind_p_o      = ind_on & tone;
  assign ind_n_o      = ind_on & ~tone;
  assign tx_inhibit_o = jab;
endmodule

// File: rtl/collision_ind_ctrl_chk.sv
module collision_ind_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic coll_det_i,
  input logic tx_valid_i,
  input logic hb_en_i,
  input logic ind_p_o,
  input logic ind_n_o,
  input logic tx_inhibit_o
);
  // R2
  legs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ind_p_o && ind_n_o));

  // R3
  coll_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coll_det_i |-> (ind_p_o || ind_n_o));

  // R4
  inhibit_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_inhibit_o |-> (ind_p_o || ind_n_o));

  // R4
  jab_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_inhibit_o) |-> $past(tx_valid_i));

  // R6
  jab_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_inhibit_o) |-> !$past(tx_valid_i));

  // R10
  hb_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hb_en_i && $past(!hb_en_i) && !coll_det_i && !tx_inhibit_o)
      |-> !(ind_p_o || ind_n_o));
endmodule

bind collision_ind_ctrl collision_ind_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .coll_det_i(coll_det_i),
  .tx_valid_i(tx_valid_i), .hb_en_i(hb_en_i), .ind_p_o(ind_p_o),
  .ind_n_o(ind_n_o), .tx_inhibit_o(tx_inhibit_o)
);

// File: tb/collision_ind_ctrl_tb.sv
module collision_ind_ctrl_tb;
  localparam int DIV = 4;
  localparam int JL  = 20;
  localparam int UT  = 30;
  localparam int HD  = 11;
  localparam int HL  = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic coll, txv, txe, hben;
  logic ip, in_, inh;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  collision_ind_ctrl #(.CLK_DIV(DIV), .JAB_LIMIT(JL), .UNJAB_TICKS(UT),
                       .HB_DELAY(HD), .HB_LEN(HL)) u_dut (
    .clk(clk), .rst_n(rst_n), .coll_det_i(coll), .tx_valid_i(txv),
    .tx_end_i(txe), .hb_en_i(hben), .ind_p_o(ip), .ind_n_o(in_),
    .tx_inhibit_o(inh)
  );

  // {coll, hb_en, cycles, expected indicator on}
  typedef struct packed { logic c; logic h; logic [7:0] n; logic on; } vec_t;
  localparam vec_t VECS [4] = '{
    '{1'b1, 1'b1, 8'd3, 1'b1},
    '{1'b0, 1'b1, 8'd2, 1'b0},
    '{1'b1, 1'b0, 8'd5, 1'b1},
    '{1'b0, 1'b0, 8'd4, 1'b0}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic on_now();
    return ip | in_;
  endfunction

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hi;
    rst_n = 1'b0; coll = 0; txv = 0; txe = 0; hben = 1;
    step(3);
    // R1 reset state
    chk("R1 legs", on_now(), 1'b0);
    chk("R1 inhibit", inh, 1'b0);
    rst_n = 1'b1;
    step(2);
    chk("R1 after release", on_now() | inh, 1'b0);

    foreach (VECS[i]) begin
      coll = VECS[i].c; hben = VECS[i].h;
      step(int'(VECS[i].n));
      // R3 collision gating / R2 idle
      chk("R3 vector", on_now(), VECS[i].on);
      chk("R2 legs", ip & in_, 1'b0);
    end
    hben = 1;

    // R3 duty of free-running tone
    coll = 1; hi = 0;
    for (int k = 0; k < 2*DIV; k++) begin
      step(1);
      hi += int'(ip);
      chk("R2 one leg", ip ^ in_, 1'b1);
    end
    checks++;
    if (hi != DIV) begin
      errors++;
      $display("FAIL R3 actual=%0d expected=%0d", hi, DIV);
    end
    coll = 0; step(1);

    // R5 interrupted runs do not trip
    txv = 1; step(JL-1); txv = 0; step(1); txv = 1; step(JL-1);
    chk("R5 no trip", inh, 1'b0);
    txv = 0; step(2);

    // R4 exact limit
    txv = 1; step(JL-1);
    chk("R4 before limit", inh, 1'b0);
    step(1);
    chk("R4 at limit", inh, 1'b1);
    chk("R4 indicator", on_now(), 1'b1);

    // R7 restart of quiet period
    txv = 0; step(15);
    txv = 1; step(1);
    txv = 0; step(UT-1);
    chk("R7 still latched", inh, 1'b1);
    // R6 release at exact count
    step(1);
    chk("R6 released", inh, 1'b0);
    chk("R6 indicator off", on_now(), 1'b0);

    // R8 heartbeat timing
    step(3);
    txe = 1; step(1); txe = 0;
    step(HD-1);
    chk("R8 before burst", on_now(), 1'b0);
    step(1);
    chk("R8 burst start", on_now(), 1'b1);
    step(HL-1);
    chk("R8 burst last", on_now(), 1'b1);
    step(1);
    chk("R8 burst end", on_now(), 1'b0);

    // R9 retrigger during delay
    txe = 1; step(1); txe = 0; step(4);
    txe = 1; step(1); txe = 0;
    step(HD-1);
    chk("R9 delay restarted", on_now(), 1'b0);
    step(1);
    chk("R9 burst after second", on_now(), 1'b1);
    step(HL);

    // R10 strap suppresses
    hben = 0; step(1);
    txe = 1; step(1); txe = 0;
    for (int k = 0; k < HD+HL+2; k++) begin
      step(1);
      if (k == HD || k == HD+3) chk("R10 no burst", on_now(), 1'b0);
    end
    // R10 pending burst dropped when strap falls
    hben = 1; txe = 1; step(1); txe = 0; step(3);
    hben = 0; step(1); hben = 1;
    step(HD+2);
    chk("R10 pending dropped", on_now(), 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule